// File: doc/BRIEF.md
# Dual Comparator Change-Flag and Interrupt Controller

This block holds the digital side of a pair of analog comparators. Each channel receives the raw comparator decision bit and a software enable. It produces a gated output bit that reads high whenever the channel is off, and a sticky change flag that software clears with a write strobe. The raw bit is synchronized first. Both flags feed one shared interrupt request, which is qualified by a comparator interrupt enable and a global interrupt enable. Software reads the flags to find the source.

A small power-mode state machine follows the requested mode. The mode is encoded on `pm_mode` as 0 run, 1 idle, 2 power-down and 3 total power-down. Its states are PM_RUN, PM_IDLE, PM_PDN and PM_TOT. Every state can move to any other state on the next clock, following the request.

Each channel is its own state machine with three states:
- CH_OFF: the output is high.
- CH_LO: enabled, and the output is low.
- CH_HI: enabled, and the output is high.

The transitions are:
- OFF→LO and OFF→HI when the channel is enabled, chosen by the synchronized input.
- LO→HI on a rising input and HI→LO on a falling input.
- LO→OFF and HI→OFF when the effective enable drops.

The block runs on an always-on low-speed clock, so flags can set and wake-up can be requested while the main oscillator is stopped.

Top module: `cmp_irq_ctrl`

## Requirements
- R1: An enabled channel presents its raw input on its output three clock edges after the raw input is sampled: two synchronizer stages, then the state register.
- R2: A channel whose effective enable is 0 reads 1 on its output from the next clock edge on, whatever its raw input is.
- R3: A channel's flag becomes 1 on the edge where its output changes value, on both rising and falling changes. The flag stays 1 until it is cleared.
- R4: Disabling a channel whose output is low sets that channel's flag, because of the forced low-to-high change. Disabling a channel whose output is already high does not set its flag.
- R5: A clear strobe clears the channel's flag on the next edge. If an output change happens on that same edge, the flag stays 1.
- R6: `irq` is 1 exactly when at least one flag is 1, `cie` is 1 and `gie` is 1.
- R7: `pwr_off`=1 forces both channels off, with effect on the next edge. `pm_mode`=3 (total power-down) also forces both channels off, one edge after the mode state machine has entered PM_TOT.
- R8: `wake` is 1 only while the mode state is PM_IDLE (code 1) or PM_PDN (code 2) and `irq` is 1. It is never 1 in PM_RUN or PM_TOT.
- R9: During and after reset, both outputs read 1, both flags read 0, and `irq` and `wake` read 0. The forced-high output seen at reset does not set a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on low-speed clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_in | input | NCH | Raw comparator decision bits (asynchronous) |
| ch_en | input | NCH | Per-channel software enable |
| pwr_off | input | 1 | Turns off both comparators |
| clr_flag | input | NCH | Per-channel flag clear strobes |
| cie | input | 1 | Comparator interrupt enable |
| gie | input | 1 | Global interrupt enable |
| pm_mode | input | 2 | Requested power mode: 0 run, 1 idle, 2 power-down, 3 total power-down |
| cmp_out | output | NCH | Gated comparator outputs |
| cmp_flag | output | NCH | Sticky change flags |
| irq | output | 1 | Shared interrupt request |
| wake | output | 1 | Wake-up request |

## Verification
The bench disables a channel while its output is low. A design that does not treat the forced high as a change would leave the flag at 0 there. The bench also lines up a clear strobe with the edge where the output changes. A design that lets the clear win would lose that event, so software would never see it. The bench holds total power-down and the power-off bit with both inputs low, to catch outputs left low or a wake-up raised from the deepest mode. A long random run compares every output, every cycle, against a model with the three-edge input latency. An off-by-one synchronizer or a flag that misses falling changes would show up as a mismatch.

// File: rtl/cmp_irq_pkg.sv
`timescale 1ns/1ps
package cmp_irq_pkg;

    // Power-mode state, encoded as the pm_mode request code
    typedef enum logic [1:0] {
        PM_RUN  = 2'd0,
        PM_IDLE = 2'd1,
        PM_PDN  = 2'd2,
        PM_TOT  = 2'd3
    } pm_state_e;

    // Per-channel output state
    typedef enum logic [1:0] {
        CH_OFF = 2'd0,
        CH_LO  = 2'd1,
        CH_HI  = 2'd2
    } ch_state_e;

    localparam int SYNC_DEPTH = 2;

endpackage

// File: rtl/cmp_sync.sv
`timescale 1ns/1ps
module cmp_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[0] <= RST_VAL;
                    else        pipe[0] <= d;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[g] <= RST_VAL;
                    else        pipe[g] <= pipe[g-1];
                end
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/cmp_chan.sv
`timescale 1ns/1ps
module cmp_chan
    import cmp_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic smp,      // synchronized comparator decision
    input  logic en_eff,   // effective enable after power gating
    input  logic clr,      // flag clear strobe
    output logic out,
    output logic flag
);
    ch_state_e state, nxt;
    logic      out_nxt;
    logic      change;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CH_OFF;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            CH_OFF: begin
                if (en_eff) nxt = smp ? CH_HI : CH_LO;
            end
            CH_LO: begin
                if (!en_eff)  nxt = CH_OFF;
                else if (smp) nxt = CH_HI;
            end
            CH_HI: begin
                if (!en_eff)   nxt = CH_OFF;
                else if (!smp) nxt = CH_LO;
            end
            default: nxt = CH_OFF;
        endcase
    end

    // Output decode and change detection
    always_comb begin
        out     = (state != CH_LO);
        out_nxt = (nxt != CH_LO);
        change  = out ^ out_nxt;
    end

    // Sticky flag: a set on the same edge beats a clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag <= 1'b0;
        else        flag <= (flag & ~clr) | change;
    end
endmodule

// File: rtl/cmp_pm_fsm.sv
`timescale 1ns/1ps
module cmp_pm_fsm
    import cmp_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] req,
    output logic       low_pwr,  // idle or power-down
    output logic       total_pd
);
    pm_state_e state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PM_RUN;
        else        state <= nxt;
    end

    always_comb begin
        unique case (req)
            2'd0:    nxt = PM_RUN;
            2'd1:    nxt = PM_IDLE;
            2'd2:    nxt = PM_PDN;
            default: nxt = PM_TOT;
        endcase
    end

    always_comb begin
        low_pwr  = 1'b0;
        total_pd = 1'b0;
        unique case (state)
            PM_RUN:  ;
            PM_IDLE: low_pwr = 1'b1;
            PM_PDN:  low_pwr = 1'b1;
            PM_TOT:  total_pd = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/cmp_irq_ctrl.sv
`timescale 1ns/1ps
module cmp_irq_ctrl
    import cmp_irq_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] raw_in,
    input  logic [NCH-1:0] ch_en,
    input  logic           pwr_off,
    input  logic [NCH-1:0] clr_flag,
    input  logic           cie,
    input  logic           gie,
    input  logic [1:0]     pm_mode,
    output logic [NCH-1:0] cmp_out,
    output logic [NCH-1:0] cmp_flag,
    output logic           irq,
    output logic           wake
);
    logic           low_pwr;
    logic           total_pd;
    logic [NCH-1:0] smp;
    logic [NCH-1:0] en_eff;

    cmp_pm_fsm u_pm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (pm_mode),
        .low_pwr  (low_pwr),
        .total_pd (total_pd)
    );

    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_ch
            cmp_sync #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b1)) u_sync (
                .clk   (clk),
                .rst_n (rst_n),
                .d     (raw_in[c]),
                .q     (smp[c])
            );

            assign en_eff[c] = ch_en[c] & ~pwr_off & ~total_pd;

            cmp_chan u_chan (
                .clk    (clk),
                .rst_n  (rst_n),
                .smp    (smp[c]),
                .en_eff (en_eff[c]),
                .clr    (clr_flag[c]),
                .out    (cmp_out[c]),
                .flag   (cmp_flag[c])
            );
        end
    endgenerate

    assign irq  = (|cmp_flag) & cie & gie;
    assign wake = low_pwr & irq;
endmodule

// File: rtl/cmp_irq_chk.sv
`timescale 1ns/1ps
module cmp_irq_chk #(
    parameter int NCH = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] ch_en,
    input logic           pwr_off,
    input logic [NCH-1:0] clr_flag,
    input logic [1:0]     pm_mode,
    input logic [NCH-1:0] cmp_out,
    input logic [NCH-1:0] cmp_flag,
    input logic           irq,
    input logic           wake
);
    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_chk
            // R2
            off_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!ch_en[c] || pwr_off) |=> cmp_out[c]);
            // R3
            flag_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !$stable(cmp_out[c]) |-> cmp_flag[c]);
            // R5
            clear_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(clr_flag[c]) && $stable(cmp_out[c])) |-> !cmp_flag[c]);
        end
    endgenerate

    // R6
    no_flag_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_flag == '0) |-> !irq);
    // R8
    wake_needs_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> irq);
    // R7
    total_pd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pm_mode == 2'd3) && $past(pm_mode == 2'd3) && $past(pm_mode == 2'd3, 2))
        |-> ((&cmp_out) && !wake));
endmodule

bind cmp_irq_ctrl cmp_irq_chk #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ch_en    (ch_en),
    .pwr_off  (pwr_off),
    .clr_flag (clr_flag),
    .pm_mode  (pm_mode),
    .cmp_out  (cmp_out),
    .cmp_flag (cmp_flag),
    .irq      (irq),
    .wake     (wake)
);

// File: tb/cmp_irq_ctrl_tb.sv
`timescale 1ns/1ps
module cmp_irq_ctrl_tb;
    localparam int NCH = 2;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [NCH-1:0] raw_in, ch_en, clr_flag;
    logic           pwr_off, cie, gie;
    logic [1:0]     pm_mode;
    logic [NCH-1:0] cmp_out, cmp_flag;
    logic           irq, wake;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // reference model state
    logic [NCH-1:0] m_s1, m_s2, m_out, m_flag;
    logic [1:0]     m_pm;

    always #2.5 clk = ~clk;

    cmp_irq_ctrl #(.NCH(NCH)) u_dut (
        .clk(clk), .rst_n(rst_n), .raw_in(raw_in), .ch_en(ch_en),
        .pwr_off(pwr_off), .clr_flag(clr_flag), .cie(cie), .gie(gie),
        .pm_mode(pm_mode), .cmp_out(cmp_out), .cmp_flag(cmp_flag),
        .irq(irq), .wake(wake)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic exp_irq();
        return (|m_flag) & cie & gie;
    endfunction

    function automatic logic exp_wake();
        return ((m_pm == 2'd1) || (m_pm == 2'd2)) & exp_irq();
    endfunction

    task automatic compare_all();
        chk(cmp_out == m_out,   "R1 R2 R7 out",      cmp_out,  m_out);
        chk(cmp_flag == m_flag, "R3 R4 R5 flag",     cmp_flag, m_flag);
        chk(irq == exp_irq(),   "R6 irq",            irq,      exp_irq());
        chk(wake == exp_wake(), "R8 wake",           wake,     exp_wake());
    endtask

    // one clock: model updates from the values held across the edge
    task automatic step();
        logic [NCH-1:0] eff, nout;
        @(posedge clk);
        eff    = ch_en & ~{NCH{pwr_off}} & ~{NCH{m_pm == 2'd3}};
        nout   = (m_s2 & eff) | ~eff;
        m_flag = (m_flag & ~clr_flag) | (nout ^ m_out);
        m_out  = nout;
        m_s2   = m_s1;
        m_s1   = raw_in;
        m_pm   = pm_mode;
        #1;
        compare_all();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 0; raw_in = '0; ch_en = '0; clr_flag = '0;
        pwr_off = 0; cie = 1; gie = 1; pm_mode = 2'd0;
        m_s1 = '1; m_s2 = '1; m_out = '1; m_flag = '0; m_pm = 2'd0;
        repeat (3) @(posedge clk);
        #1;
        // R9 reset state
        chk(cmp_out == '1, "R9 out at reset", cmp_out, '1);
        chk(cmp_flag == '0, "R9 flag at reset", cmp_flag, '0);
        chk(irq == 0, "R9 irq at reset", irq, 0);
        chk(wake == 0, "R9 wake at reset", wake, 0);
        rst_n = 1;
        step();
        chk(cmp_flag == '0, "R9 no flag after reset", cmp_flag, '0);

        // R4: enable with low inputs, clear, then disable channel 0
        ch_en = '1;
        repeat (4) step();
        clr_flag = '1; step(); clr_flag = '0; step();
        chk(cmp_out == '0, "R1 outputs low", cmp_out, '0);
        ch_en[0] = 0; step();
        chk(cmp_flag[0] == 1, "R4 disable-while-low flag", cmp_flag[0], 1);
        chk(cmp_out[0] == 1, "R2 disabled output", cmp_out[0], 1);
        clr_flag = '1; step(); clr_flag = '0;
        ch_en[1] = 1; raw_in[1] = 1; step(); step();
        // R5 collision: clear on the edge where the change lands
        clr_flag[1] = 1; step(); clr_flag[1] = 0;
        chk(cmp_flag[1] == 1, "R5 set beats clear", cmp_flag[1], 1);
        clr_flag[1] = 1; step(); clr_flag[1] = 0;
        chk(cmp_flag[1] == 0, "R5 clear alone", cmp_flag[1], 0);
        // R4: disable while high does not flag
        ch_en[1] = 0; step();
        chk(cmp_flag[1] == 0, "R4 disable-while-high no flag", cmp_flag[1], 0);

        // R7/R8 total power-down with inputs low
        ch_en = '1; raw_in = '0; repeat (4) step();
        clr_flag = '1; step(); clr_flag = '0;
        pm_mode = 2'd3; step(); step();
        chk(cmp_out == '1, "R7 total power-down forces off", cmp_out, '1);
        chk(wake == 0, "R8 no wake in total power-down", wake, 0);
        pm_mode = 2'd0; clr_flag = '1; step(); clr_flag = '0; repeat (3) step();
        // R8 wake from idle
        pm_mode = 2'd1; step(); raw_in[0] = 1; repeat (3) step();
        chk(wake == 1, "R8 wake in idle", wake, 1);
        // R7 power-off bit
        pm_mode = 2'd0; clr_flag = '1; step(); clr_flag = '0;
        pwr_off = 1; step();
        chk(cmp_out == '1, "R7 power-off forces off", cmp_out, '1);
        pwr_off = 0;

        // constrained random phase
        for (int i = 0; i < 4000; i++) begin
            raw_in = NCH'($urandom);
            if (($urandom % 8) == 0) ch_en = NCH'($urandom);
            clr_flag = (($urandom % 6) == 0) ? NCH'($urandom) : '0;
            cie = ($urandom % 5) != 0;
            gie = ($urandom % 5) != 0;
            if (($urandom % 32) == 0) pm_mode = 2'($urandom);
            if (($urandom % 64) == 0) pwr_off = ~pwr_off;
            step();
        end
        finish_run();
    end
endmodule